// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 64-bit integer by another over many clock cycles. It produces a quotient and a remainder, and it can treat the operands as either unsigned or two's-complement signed. A caller puts the operands on the inputs, selects the mode and pulses `start`. The block raises `busy` while it works. When the results are ready, it pulses `done` for one cycle. The results stay on the outputs until the next operation finishes.

The datapath uses one accumulator that is twice the operand width. The partial remainder sits in the upper half and the quotient grows in the lower half. Each cycle does one restoring step. The accumulator shifts left, and the divisor is trial-subtracted from the upper half in the same step. The sign of that subtraction sets the new quotient bit and decides whether the shifted value is kept or replaced by the difference. Each step depends on the result of the one before it, so the steps run one after another. In signed mode the block divides the operand magnitudes and fixes the signs in one extra cycle at the end. The block does not flag divide-by-zero or signed overflow. Software is expected to check for these. The block still gives a defined result for both cases in the normal number of cycles.

Top module: `seq_restoring_div`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `quotient` and `remainder` are all zero until an operation completes.
- R2: With `is_signed`=0, the block computes the unsigned floor quotient and remainder: dividend = quotient*divisor + remainder, with remainder < divisor, for any nonzero divisor.
- R3: With `is_signed`=1, the quotient is the two's-complement quotient truncated toward zero. It is negative exactly when the dividend and the divisor have opposite signs.
- R4: With `is_signed`=1, the remainder carries the sign of the dividend, or is zero, and dividend = quotient*divisor + remainder holds.
- R5: Count the rising edge that samples `start` as edge 1. Then `done` is high for exactly one cycle after rising edge W+2 (66 for W=64). `busy` is high from edge 1 until `done` rises, and it is low while `done` is high.
- R6: A `start` pulse while `busy` is high is ignored. It does not change the result or the timing of the operation in progress, and it produces no extra `done`.
- R7: With a zero divisor, in either mode, the quotient is all ones and the remainder equals the dividend. The latency is the same as in R5.
- R8: A signed division of the most negative value by -1 wraps. The quotient is the most negative value and the remainder is zero.
- R9: `quotient` and `remainder` change only on the edge where `done` rises. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Dividend, sampled with start |
| divisor | input | W | Divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results update |
| quotient | output | W | Quotient of the last division |
| remainder | output | W | Remainder of the last division |

## Verification
The bound checker watches the handshake on every cycle:
- `done` is a one-cycle pulse that never overlaps `busy`.
- `done` arrives exactly W+2 edges after an accepted start, whatever `start` does in between.
- The outputs move only when `done` rises.
- An unsigned result always has a remainder below its nonzero divisor.
- A zero divisor always yields all ones and the dividend.

The actual quotient values can only be confirmed by the bench scenarios. For example, the sign fixes for each combination of operand signs, the wrapping case of the most negative value divided by -1, and exact quotients under varied operand patterns are checked against reference arithmetic.

// File: rtl/div_pkg.sv
// Package: shared state encoding for the sequential divider.
// Assumes: the control FSM has three phases (idle, iterate, sign fixup).
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Turns a possibly signed operand into an unsigned magnitude plus a sign flag.
// Assumes: two's complement; the most negative value maps to 2^(W-1) unsigned.
module div_operand_prep #(
    parameter int W = 64
) (
    input  logic         signed_mode,
    input  logic [W-1:0] value_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    // Select negation only for signed operands with the top bit set.
    always_comb begin
        neg_o = signed_mode & value_i[W-1];
        mag_o = neg_o ? (~value_i + W'(1)) : value_i;
    end
endmodule

// File: rtl/div_restore_step.sv
// Module: div_restore_step
// One restoring iteration on a 2W-bit accumulator: shift left, trial-subtract
// the divisor from the upper half, keep or restore, shift in the quotient bit.
// Assumes: upper half of acc_i is smaller than dvs_i, or dvs_i is zero.
module div_restore_step #(
    parameter int W = 64
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   dvs_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] hi_shift;
    logic [W:0] trial;
    logic       below;

    // Shift, subtract and choose the next accumulator value in one pass.
    always_comb begin
        hi_shift = acc_i[2*W-1:W-1];
        trial    = hi_shift - {1'b0, dvs_i};
        below    = hi_shift < {1'b0, dvs_i};
        if (below)
            acc_o = {hi_shift[W-1:0], acc_i[W-2:0], 1'b0};
        else
            acc_o = {trial[W-1:0], acc_i[W-2:0], 1'b1};
    end
endmodule

// File: rtl/div_sign_fix.sv
// Module: div_sign_fix
// Applies final signs to magnitude results of the iteration.
// Assumes: remainder follows the dividend sign; quotient negation is
// suppressed for a zero divisor so the all-ones pattern survives.
module div_sign_fix #(
    parameter int W = 64
) (
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    output logic [W-1:0] q_o,
    output logic [W-1:0] r_o
);
    // Conditionally negate each result independently.
    always_comb begin
        q_o = neg_q ? (~q_mag + W'(1)) : q_mag;
        r_o = neg_r ? (~r_mag + W'(1)) : r_mag;
    end
endmodule

// File: rtl/seq_restoring_div.sv
// Module: seq_restoring_div (top)
// Multi-cycle restoring divider, signed or unsigned, with start/busy/done.
// One capture cycle, W iteration cycles, one sign-fix cycle.
// Assumes: start is ignored while busy; no divide-by-zero or overflow trap.
module seq_restoring_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    import div_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e     state_q;
    logic [2*W-1:0] acc_q;
    logic [2*W-1:0] acc_next;
    logic [W-1:0]   dvs_q;
    logic [CW-1:0]  step_q;
    logic           neg_q_q;
    logic           neg_r_q;
    logic [W-1:0]   a_mag, b_mag;
    logic           a_neg, b_neg;
    logic [W-1:0]   q_fixed, r_fixed;
    logic           accept;

    div_operand_prep #(.W(W)) u_prep_a (
        .signed_mode (is_signed),
        .value_i     (dividend),
        .mag_o       (a_mag),
        .neg_o       (a_neg)
    );

    div_operand_prep #(.W(W)) u_prep_b (
        .signed_mode (is_signed),
        .value_i     (divisor),
        .mag_o       (b_mag),
        .neg_o       (b_neg)
    );

    div_restore_step #(.W(W)) u_step (
        .acc_i (acc_q),
        .dvs_i (dvs_q),
        .acc_o (acc_next)
    );

    div_sign_fix #(.W(W)) u_fix (
        .neg_q (neg_q_q),
        .neg_r (neg_r_q),
        .q_mag (acc_q[W-1:0]),
        .r_mag (acc_q[2*W-1:W]),
        .q_o   (q_fixed),
        .r_o   (r_fixed)
    );

    // A new operation is accepted only from idle.
    always_comb accept = start && (state_q == ST_IDLE);

    // Busy covers capture through the sign-fix cycle.
    always_comb busy = (state_q != ST_IDLE);

    // Control FSM and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    step_q  <= '0;
                end
                ST_RUN: begin
                    step_q <= step_q + CW'(1);
                    if (step_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath: capture magnitudes and signs, then one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            dvs_q   <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
        end else if (accept) begin
            acc_q   <= {{W{1'b0}}, a_mag};
            dvs_q   <= b_mag;
            neg_q_q <= (a_neg ^ b_neg) && (divisor != '0);
            neg_r_q <= a_neg;
        end else if (state_q == ST_RUN) begin
            acc_q <= acc_next;
        end
    end

    // Result registers and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
        end else begin
            done <= (state_q == ST_FIX);
            if (state_q == ST_FIX) begin
                quotient  <= q_fixed;
                remainder <= r_fixed;
            end
        end
    end
endmodule

// File: rtl/seq_restoring_div_checker.sv
// Module: seq_restoring_div_checker
// Port-level protocol and result properties, bound to the divider.
// Assumes: same W as the bound instance.
module seq_restoring_div_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_signed,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    logic         live;
    logic [15:0]  cyc;
    logic [W-1:0] a_lat, b_lat;
    logic         s_lat;

    // Track an accepted operation: elapsed cycles and its operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            cyc   <= '0;
            a_lat <= '0;
            b_lat <= '0;
            s_lat <= 1'b0;
        end else if (start && !busy && !live) begin
            live  <= 1'b1;
            cyc   <= '0;
            a_lat <= dividend;
            b_lat <= divisor;
            s_lat <= is_signed;
        end else if (live) begin
            cyc <= cyc + 16'd1;
            if (done) live <= 1'b0;
        end
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (live && cyc == 16'(W + 1)));
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));
    p_hold_q_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quotient) |-> done);
    p_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remainder) |-> done);
    p_unsigned_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !s_lat && b_lat != '0) |-> (remainder < b_lat));
    p_divzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_lat == '0) |-> (quotient == '1 && remainder == a_lat));
endmodule

bind seq_restoring_div seq_restoring_div_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/seq_restoring_div_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module seq_restoring_div_bench;
    localparam int W = 64;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    seq_restoring_div #(.W(W)) u_seq_restoring_div (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input bit sgn, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input string tag);
        exp_t e;
        e.tag = tag;
        if (b == '0) begin
            e.q = '1; e.r = a;                       // R7
        end else if (!sgn) begin
            e.q = a / b; e.r = a % b;                // R2
        end else if (a == MINV && b == '1) begin
            e.q = MINV; e.r = '0;                    // R8
        end else begin
            e.q = $signed(a) / $signed(b);           // R3
            e.r = $signed(a) - $signed(e.q) * $signed(b); // R4
        end
        return e;
    endfunction

    // Monitor: pop and compare on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected done", quotient, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q, {e.tag, " quotient"}, quotient, e.q);
                check(remainder == e.r, {e.tag, " remainder"}, remainder, e.r);
            end
        end
    end

    // Driver: queue expectation, start, measure latency; optional extra start.
    task automatic run_op(input bit sgn, input logic [W-1:0] a,
                          input logic [W-1:0] b, input string tag,
                          input bit poke);
        int k;
        sb.push_back(model(sgn, a, b, tag));
        @(negedge clk);
        is_signed = sgn; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        check(busy == 1'b1, "R5 busy after start", {63'd0, busy}, 1);
        while (!done && k < 200) begin
            if (poke && k == 10) begin
                start = 1'b1; dividend = 64'd5; divisor = 64'd3; is_signed = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(k == W + 2, "R5 latency", 64'(k), 64'(W + 2));
        check(busy == 1'b0, "R5 busy low at done", {63'd0, busy}, 0);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", {63'd0, done}, 0);
    endtask

    initial begin
        logic [W-1:0] hq, hr;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R1 reset flags", {62'd0, busy, done}, 0);
        check(quotient == 0 && remainder == 0, "R1 reset data", quotient, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(quotient == 0 && remainder == 0 && !busy, "R1 after release", quotient, 0);

        run_op(0, 64'd100, 64'd7, "R2 100/7", 0);
        run_op(0, '1, 64'd1, "R2 max/1", 0);
        run_op(0, '1, '1, "R2 max/max", 0);
        run_op(0, 64'd3, 64'h8000_0000_0000_0001, "R2 small/large", 0);
        run_op(0, 64'hFFFF_0000_1234_5678, 64'h0000_0000_0001_0003, "R2 pattern", 0);
        run_op(1, -64'sd100, 64'd7, "R3 R4 neg/pos", 0);
        run_op(1, 64'd100, -64'sd7, "R3 R4 pos/neg", 0);
        run_op(1, -64'sd100, -64'sd7, "R3 R4 neg/neg", 0);
        run_op(1, 64'd6, 64'd7, "R3 zero quotient", 0);
        run_op(1, MINV, 64'd2, "R3 min/2", 0);
        run_op(1, MINV, '1, "R8 min/-1", 0);
        run_op(0, 64'h1234, 64'd0, "R7 unsigned zero", 0);
        run_op(1, -64'sd77, 64'd0, "R7 signed zero", 0);
        run_op(0, 64'd1000, 64'd9, "R6 start while busy", 1);
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom} >> (i * 9);
            run_op(i[0], a, b, "R2 R3 R4 varied", 0);
        end

        hq = quotient; hr = remainder;
        is_signed = 1'b1; dividend = 64'd55; divisor = 64'd4;
        repeat (20) @(negedge clk);
        check(quotient == hq && remainder == hr, "R9 hold while idle", quotient, hq);
        check(sb.size() == 0, "R6 scoreboard drained", 64'(sb.size()), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule